// File: doc/BRIEF.md
# Two-Level Short-Format Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table in the short (32-bit entry) format. A requester gives it a virtual address and the base of the first-level table in one cycle. The walker then issues 32-bit descriptor reads on a simple valid/ready request channel. Each read is answered by one response on a separate valid channel.

The first-level entry either maps a 1 MB section directly or points to a second-level table. A second-level entry maps a 64 KB large page or a 4 KB small page. At the end of a walk the block pulses `done` for one cycle. The result ports then carry:
- the physical address,
- a size code,
- the 3-bit access permission,
- the execute-never flag,
- the global flag,
- a fault code.

The result ports keep these values until the next walk finishes. Only one walk is in flight at a time. A start request that arrives while the walker is busy is dropped.

The controller has six states:
- `ST_IDLE`: waits for `start_valid`.
- `ST_L1_REQ`: presents the first-level read until `mem_req_ready`.
- `ST_L1_WAIT`: waits for the first response.
- `ST_L2_REQ`: presents the second-level read.
- `ST_L2_WAIT`: waits for the second response.
- `ST_DONE`: holds for one cycle with `done` high.

The transitions are:
- **accept**: `ST_IDLE` to `ST_L1_REQ`.
- **issue1**: `ST_L1_REQ` to `ST_L1_WAIT`.
- **chain**: `ST_L1_WAIT` to `ST_L2_REQ`, taken when the first-level entry is a table pointer.
- **finish1**: `ST_L1_WAIT` to `ST_DONE`, taken for a section or a fault.
- **issue2**: `ST_L2_REQ` to `ST_L2_WAIT`.
- **finish2**: `ST_L2_WAIT` to `ST_DONE`.
- **retire**: `ST_DONE` to `ST_IDLE`.

Top module: `ptw_short2l`

## Requirements
- R1: After reset, and whenever `busy` is low, `mem_req_valid` and `done` are low.
- R2: The first read address is {start_base[31:14], start_va[31:20], 2'b00}. Every read request keeps `mem_req_valid` high and `mem_req_addr` unchanged until `mem_req_ready` is seen.
- R3: A first-level entry with bits [1:0] = 2'b10 and bit 18 clear is a section, and the walk ends after one read. The results are: pa = {d[31:20], va[19:0]}, size code 0, ap = {d[15], d[11:10]}, xn = d[4], global = ~d[17], fault code 0.
- R4: A first-level entry with bits [1:0] = 2'b00 or 2'b11 ends the walk after one read with fault code 1.
- R5: A section entry with bit 18 set ends the walk after one read with fault code 3 (unsupported).
- R6: A first-level entry with bits [1:0] = 2'b01 causes a second read at address {d[31:10], va[19:12], 2'b00}.
- R7: A second-level entry with bits [1:0] = 2'b01 is a large page. The results are: pa = {d[31:16], va[15:0]}, size code 1, xn = d[15], ap = {d[9], d[5:4]}, global = ~d[11], fault code 0.
- R8: A second-level entry with bit 1 set is a small page. The results are: pa = {d[31:12], va[11:0]}, size code 2, xn = d[0], ap = {d[9], d[5:4]}, global = ~d[11], fault code 0.
- R9: A second-level entry with bits [1:0] = 2'b00 ends the walk with fault code 2.
- R10: `done` is high for exactly one cycle per walk. A `start_valid` that is seen while `busy` is high is ignored, and this includes the `done` cycle.
- R11: Whenever the fault code is non-zero, pa, size, ap, xn and global are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start a walk (taken only when idle) |
| start_va | input | 32 | Virtual address to translate |
| start_base | input | 32 | First-level table base (16 KB aligned) |
| busy | output | 1 | Walk in progress, including the done cycle |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_req_ready | input | 1 | Request accepted |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| done | output | 1 | One-cycle completion pulse |
| res_pa | output | 32 | Physical address |
| res_size | output | 2 | 0 section, 1 large page, 2 small page |
| res_ap | output | 3 | Access permission |
| res_xn | output | 1 | Execute-never |
| res_global | output | 1 | Mapping is global |
| res_fault | output | 2 | 0 none, 1 first-level, 2 second-level, 3 unsupported |

## Verification
Two events can fall in the same cycle:
- a new start request and the completion pulse of the walk before it;
- a new start request and a stalled read request.

The bench provokes both. It raises `start_valid` with a different address during stalled request cycles, and again in the `done` cycle. It then judges that the request address stays unchanged and that no new request or busy state follows the pulse.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int unsigned PTW_AW        = 32;
    localparam int unsigned PTW_DW        = 32;
    localparam int unsigned L1_BASE_LSB   = 14;
    localparam int unsigned L1_IDX_LSB    = 20;
    localparam int unsigned L2_IDX_LSB    = 12;
    localparam int unsigned SEC_OFS_W     = 20;
    localparam int unsigned LARGE_OFS_W   = 16;
    localparam int unsigned SMALL_OFS_W   = 12;

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        SZ_SECTION = 2'd0, SZ_LARGE = 2'd1, SZ_SMALL = 2'd2
    } map_size_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0, FLT_L1_XLAT = 2'd1, FLT_L2_XLAT = 2'd2, FLT_UNSUP = 2'd3
    } walk_fault_e;

    typedef struct packed {
        logic [PTW_AW-1:0] pa;
        logic [1:0]        size;
        logic [2:0]        ap;
        logic              xn;
        logic              glob;
        logic [1:0]        fault;
    } walk_result_t;
endpackage

// File: rtl/ptw_l1_dec.sv
module ptw_l1_dec
    import ptw_pkg::*;
(
    input  logic [PTW_DW-1:0]      desc,
    input  logic [L1_IDX_LSB-1:0]  va_lo,
    output logic                   is_table,
    output walk_result_t           res,
    output logic [PTW_AW-1:0]      l2_addr
);
    logic unused_l1_bits;
    assign unused_l1_bits = ^{desc[9:5], desc[3:2]};

    assign l2_addr = {desc[31:10], va_lo[L1_IDX_LSB-1:L2_IDX_LSB], 2'b00};

    always_comb begin
        res      = '0;
        is_table = 1'b0;
        unique case (desc[1:0])
            2'b01: is_table = 1'b1;
            2'b10: begin
                if (desc[18]) begin
                    res.fault = FLT_UNSUP;
                end else begin
                    res.pa   = {desc[31:SEC_OFS_W], va_lo[SEC_OFS_W-1:0]};
                    res.size = SZ_SECTION;
                    res.ap   = {desc[15], desc[11:10]};
                    res.xn   = desc[4];
                    res.glob = ~desc[17];
                end
            end
            default: res.fault = FLT_L1_XLAT;
        endcase
    end
endmodule

// File: rtl/ptw_l2_dec.sv
module ptw_l2_dec
    import ptw_pkg::*;
(
    input  logic [PTW_DW-1:0]      desc,
    input  logic [LARGE_OFS_W-1:0] va_lo,
    output walk_result_t           res
);
    logic unused_l2_bits;
    assign unused_l2_bits = ^{desc[10], desc[8:6], desc[3:2]};

    always_comb begin
        res = '0;
        if (desc[1:0] == 2'b00) begin
            res.fault = FLT_L2_XLAT;
        end else begin
            res.ap   = {desc[9], desc[5:4]};
            res.glob = ~desc[11];
            if (!desc[1]) begin
                res.pa   = {desc[31:LARGE_OFS_W], va_lo};
                res.size = SZ_LARGE;
                res.xn   = desc[15];
            end else begin
                res.pa   = {desc[31:SMALL_OFS_W], va_lo[SMALL_OFS_W-1:0]};
                res.size = SZ_SMALL;
                res.xn   = desc[0];
            end
        end
    end
endmodule

// File: rtl/ptw_short2l.sv
module ptw_short2l
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    input  logic [31:0]       start_va,
    input  logic [31:0]       start_base,
    output logic              busy,
    output logic              mem_req_valid,
    output logic [31:0]       mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              done,
    output logic [31:0]       res_pa,
    output logic [1:0]        res_size,
    output logic [2:0]        res_ap,
    output logic              res_xn,
    output logic              res_global,
    output logic [1:0]        res_fault
);
    walk_state_e         state_q, state_d;
    logic [PTW_AW-1:0]   va_q;
    logic [PTW_AW-1:0]   addr_q;
    walk_result_t        result_q;

    logic                l1_is_table;
    walk_result_t        l1_res;
    walk_result_t        l2_res;
    logic [PTW_AW-1:0]   l2_addr;

    logic unused_base_bits;
    assign unused_base_bits = ^start_base[L1_BASE_LSB-1:0];

    ptw_l1_dec u_l1 (
        .desc     (mem_rsp_data),
        .va_lo    (va_q[L1_IDX_LSB-1:0]),
        .is_table (l1_is_table),
        .res      (l1_res),
        .l2_addr  (l2_addr)
    );

    ptw_l2_dec u_l2 (
        .desc  (mem_rsp_data),
        .va_lo (va_q[LARGE_OFS_W-1:0]),
        .res   (l2_res)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_valid)   state_d = ST_L1_REQ;
            ST_L1_REQ:  if (mem_req_ready) state_d = ST_L1_WAIT;
            ST_L1_WAIT: if (mem_rsp_valid) state_d = l1_is_table ? ST_L2_REQ : ST_DONE;
            ST_L2_REQ:  if (mem_req_ready) state_d = ST_L2_WAIT;
            ST_L2_WAIT: if (mem_rsp_valid) state_d = ST_DONE;
            ST_DONE:                       state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk data and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q     <= '0;
            addr_q   <= '0;
            result_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_valid) begin
                    va_q   <= start_va;
                    addr_q <= {start_base[PTW_AW-1:L1_BASE_LSB],
                               start_va[PTW_AW-1:L1_IDX_LSB], 2'b00};
                end
                ST_L1_WAIT: if (mem_rsp_valid) begin
                    if (l1_is_table) addr_q   <= l2_addr;
                    else             result_q <= l1_res;
                end
                ST_L2_WAIT: if (mem_rsp_valid) result_q <= l2_res;
                default: ;
            endcase
        end
    end

    assign busy          = (state_q != ST_IDLE);
    assign mem_req_valid = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
    assign mem_req_addr  = addr_q;
    assign done          = (state_q == ST_DONE);
    assign res_pa        = result_q.pa;
    assign res_size      = result_q.size;
    assign res_ap        = result_q.ap;
    assign res_xn        = result_q.xn;
    assign res_global    = result_q.glob;
    assign res_fault     = result_q.fault;
endmodule

// File: rtl/ptw_short2l_chk.sv
module ptw_short2l_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] start_va,
    input logic [31:0] start_base,
    input logic        busy,
    input logic        mem_req_valid,
    input logic [31:0] mem_req_addr,
    input logic        mem_req_ready,
    input logic        done,
    input logic [31:0] res_pa,
    input logic [1:0]  res_size,
    input logic [2:0]  res_ap,
    input logic        res_xn,
    input logic        res_global,
    input logic [1:0]  res_fault
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req_valid && !done)); // R1

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R2

    AST_L1_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req_valid) && !$past(busy)) |->
        (mem_req_addr == {$past(start_base[31:14]), $past(start_va[31:20]), 2'b00})); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done)); // R10

    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_fault != 2'd0) |->
        (res_pa == 32'd0 && res_size == 2'd0 && res_ap == 3'd0 && !res_xn && !res_global)); // R11
endmodule

bind ptw_short2l ptw_short2l_chk u_chk (.*);

// File: tb/sim_ptw_short2l.sv
`timescale 1ns/1ps
module sim_ptw_short2l;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_valid = 1'b0;
    logic [31:0] start_va = '0;
    logic [31:0] start_base = '0;
    logic        busy;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done;
    logic [31:0] res_pa;
    logic [1:0]  res_size;
    logic [2:0]  res_ap;
    logic        res_xn;
    logic        res_global;
    logic [1:0]  res_fault;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int          nreq;
    logic [31:0] alog [0:3];
    logic [31:0] r_pa;
    logic [1:0]  r_size, r_fault;
    logic [2:0]  r_ap;
    logic        r_xn, r_g;

    always #4 clk = ~clk;

    ptw_short2l u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic walk(input logic [31:0] va, input logic [31:0] base,
                        input logic [31:0] d1, input logic [31:0] d2,
                        input int stall, input bit poke);
        int guard = 0;
        bit seen = 0;
        nreq = 0;
        start_valid = 1; start_va = va; start_base = base;
        @(negedge clk);
        start_valid = 0;
        while (!seen && guard < 40) begin
            guard++;
            if (done) begin
                seen = 1;
                r_pa = res_pa; r_size = res_size; r_ap = res_ap;
                r_xn = res_xn; r_g = res_global; r_fault = res_fault;
            end else if (mem_req_valid) begin
                alog[nreq & 3] = mem_req_addr;
                for (int i = 0; i < stall; i++) begin
                    if (poke) begin start_valid = 1; start_va = ~va; start_base = ~base; end
                    @(negedge clk);
                    start_valid = 0;
                    chk("R2 request held", {31'd0, mem_req_valid}, 32'd1);
                    chk("R2 address stable (start ignored R10)", mem_req_addr, alog[nreq & 3]);
                end
                mem_req_ready = 1;
                @(negedge clk);
                mem_req_ready = 0;
                mem_rsp_valid = 1;
                mem_rsp_data = (nreq == 0) ? d1 : d2;
                nreq++;
                @(negedge clk);
                mem_rsp_valid = 0;
            end else begin
                @(negedge clk);
            end
        end
        chk("R10 done seen", {31'd0, seen}, 32'd1);
        if (poke) begin start_valid = 1; start_va = va; start_base = base; end
        @(negedge clk);
        start_valid = 0;
        chk("R10 done lasts one cycle", {31'd0, done}, 32'd0);
        chk("R10 start in done cycle ignored (busy)", {31'd0, busy}, 32'd0);
        chk("R10 start in done cycle ignored (req)", {31'd0, mem_req_valid}, 32'd0);
    endtask

    task automatic expect_res(input string tag, input logic [31:0] pa, input logic [1:0] sz,
                              input logic [2:0] ap, input logic xn, input logic g,
                              input logic [1:0] flt, input int reads);
        chk({tag, " pa"}, r_pa, pa);
        chk({tag, " size"}, {30'd0, r_size}, {30'd0, sz});
        chk({tag, " ap"}, {29'd0, r_ap}, {29'd0, ap});
        chk({tag, " xn"}, {31'd0, r_xn}, {31'd0, xn});
        chk({tag, " global"}, {31'd0, r_g}, {31'd0, g});
        chk({tag, " fault"}, {30'd0, r_fault}, {30'd0, flt});
        chk({tag, " reads"}, nreq, reads);
    endtask

    task automatic t_reset();
        chk("R1 busy after reset", {31'd0, busy}, 32'd0);
        chk("R1 no request after reset", {31'd0, mem_req_valid}, 32'd0);
        chk("R1 no done after reset", {31'd0, done}, 32'd0);
    endtask

    task automatic t_section(input logic [31:0] va, input logic [31:0] base,
                             input logic [31:0] d1, input int stall, input bit poke);
        walk(va, base, d1, 32'd0, stall, poke);
        chk("R2 first-level address", alog[0], {base[31:14], va[31:20], 2'b00});
        expect_res("R3 section", {d1[31:20], va[19:0]}, 2'd0, {d1[15], d1[11:10]},
                   d1[4], ~d1[17], 2'd0, 1);
    endtask

    task automatic t_l1_fault(input logic [31:0] d1);
        walk(32'h0765_4321, 32'h0000_C000, d1, 32'd0, 0, 0);
        expect_res("R4 R11 first-level fault", 32'd0, 2'd0, 3'd0, 1'b0, 1'b0, 2'd1, 1);
    endtask

    task automatic t_super();
        walk(32'hFEDC_BA98, 32'h1111_4000, 32'hFFF4_8C12, 32'd0, 1, 0);
        expect_res("R5 R11 supersection", 32'd0, 2'd0, 3'd0, 1'b0, 1'b0, 2'd3, 1);
    endtask

    task automatic t_page(input logic [31:0] va, input logic [31:0] d1,
                          input logic [31:0] d2, input int stall, input bit poke);
        walk(va, 32'h2000_8000, d1, d2, stall, poke);
        chk("R6 second-level address", alog[1], {d1[31:10], va[19:12], 2'b00});
        if (d2[1:0] == 2'b00)
            expect_res("R9 R11 second-level fault", 32'd0, 2'd0, 3'd0, 1'b0, 1'b0, 2'd2, 2);
        else if (!d2[1])
            expect_res("R7 large page", {d2[31:16], va[15:0]}, 2'd1, {d2[9], d2[5:4]},
                       d2[15], ~d2[11], 2'd0, 2);
        else
            expect_res("R8 small page", {d2[31:12], va[11:0]}, 2'd2, {d2[9], d2[5:4]},
                       d2[0], ~d2[11], 2'd0, 2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_section(32'h1234_5678, 32'h8000_4000, 32'hABC2_8412, 0, 0);
        t_section(32'hFFF0_0ABC, 32'h0003_C000, 32'h0010_0802, 3, 1);
        t_l1_fault(32'hFFFF_FFFC);
        t_l1_fault(32'h1234_5673);
        t_super();
        t_page(32'hCAFE_1234, 32'h4567_8C01, 32'hBEEF_8221, 0, 0);
        t_page(32'h0ABC_DEF0, 32'h4567_8C01, 32'h1357_9833, 2, 1);
        t_page(32'h3300_5A5A, 32'h0000_0401, 32'h2468_A002, 1, 0);
        t_page(32'h5555_AAAA, 32'h7777_7C01, 32'hFFFF_FFFC, 0, 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule